// File: doc/BRIEF.md
# Multicycle Shared-Bus Processor Core

This block is a very small processor core. It has eight general registers, an operand latch, a result latch, an instruction latch and a single shared data bus. Every transfer between storage elements crosses that one bus, which a multiplexer drives. A step sequencer runs each instruction over one to three numbered time steps. While it idles in the fetch step, it copies the data input into the instruction latch. When the start input is high, it leaves the fetch step. It raises a completion flag in the last step of each instruction.

Instruction words arrive on the data input. There is no memory and no program counter. The environment presents a word, holds `run` high for one clock edge, and then watches `done`. For a load-immediate instruction, the constant must be on the data input during the step that follows capture. The current bus value is visible at an output, so the progress of each instruction can be observed cycle by cycle.

Top module: `bus_cpu`

## Requirements
- R1: While the sequencer is in the fetch step, `done` is low and `bus_out` is zero. The sequencer stays in the fetch step for as long as `run` is low.
- R2: At a rising edge in the fetch step with `run` high, the data input is captured as the instruction. Bits 8:6 hold the opcode, bits 5:3 the destination register X and bits 2:0 the source register Y. At most one source drives the bus in any cycle.
- R3: Opcode 000 (copy) takes one step after capture. In that step the bus carries register Y, register X loads the bus value, and `done` is high.
- R4: Opcode 001 (load immediate) takes one step after capture. In that step the bus carries the data input, register X loads it, and `done` is high. The Y field has no effect.
- R5: Opcode 010 (add) takes three steps after capture. Step 1 puts register X on the bus. Step 2 puts register Y on the bus. Step 3 puts the sum on the bus, loads it into register X and raises `done`. `done` is low in steps 1 and 2.
- R6: Opcode 011 (subtract) has the same step timing as R5 and writes X minus Y into register X.
- R7: Sums and differences are taken modulo 2^9. Carries and borrows out of bit 8 are dropped.
- R8: Opcodes 100 to 111 take one step after capture. In that step `done` is high, the bus is zero, and no register changes.
- R9: In the cycle after `done` is high, the sequencer is back in the fetch step.
- R10: A low `rst_n` forces the fetch step at once, without waiting for a clock edge. An arithmetic instruction that is cut off by reset before its step 3 leaves register X unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the step sequencer |
| run | input | 1 | Start: leave the fetch step at the next edge |
| din | input | 9 | Instruction word in the fetch step; constant for load immediate |
| done | output | 1 | High in the final step of an instruction |
| bus_out | output | 9 | Current value on the shared bus |

## Verification
The bench builds the block with its default parameters: a 9-bit word and eight registers. With those values, the 3-bit select fields reach every register, and values near 0x1FF drive both the sum and the difference across the 2^9 wrap. Each register's contents are read back through the bus with a copy of that register onto itself. This makes register changes, and the absence of changes after a reserved opcode or an interrupted add, visible at the ports.

// File: rtl/bus_cpu_pkg.sv
package bus_cpu_pkg;
  typedef enum logic [1:0] {
    STEP_FETCH = 2'd0,
    STEP_1     = 2'd1,
    STEP_2     = 2'd2,
    STEP_3     = 2'd3
  } step_t;

  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_MOVE  = 3'b000;
  localparam logic [OPC_W-1:0] OPC_LOADI = 3'b001;
  localparam logic [OPC_W-1:0] OPC_ADD   = 3'b010;
  localparam logic [OPC_W-1:0] OPC_SUB   = 3'b011;
endpackage

// File: rtl/bus_cpu_ctrl.sv
module bus_cpu_ctrl
  import bus_cpu_pkg::*;
#(
  parameter int NREG = 8,
  localparam int SEL_W = $clog2(NREG),
  localparam int IR_W = OPC_W + 2 * SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [IR_W-1:0] ir,
  output step_t           step,
  output logic            ir_load,
  output logic            a_load,
  output logic            g_load,
  output logic            sub_sel,
  output logic            g_oe,
  output logic            din_oe,
  output logic            done,
  output logic [NREG-1:0] reg_we,
  output logic [NREG-1:0] reg_oe
);
  logic [OPC_W-1:0] opc;
  logic [SEL_W-1:0] rx, ry;
  logic             is_arith;
  step_t            step_d;

  assign opc      = ir[IR_W-1 -: OPC_W];
  assign rx       = ir[2*SEL_W-1 -: SEL_W];
  assign ry       = ir[SEL_W-1:0];
  assign is_arith = (opc == OPC_ADD) || (opc == OPC_SUB);

  always_comb begin
    step_d = STEP_FETCH;
    case (step)
      STEP_FETCH: step_d = run ? STEP_1 : STEP_FETCH;
      STEP_1:     step_d = is_arith ? STEP_2 : STEP_FETCH;
      STEP_2:     step_d = STEP_3;
      default:    step_d = STEP_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= STEP_FETCH;
    else        step <= step_d;
  end

  always_comb begin
    ir_load = 1'b0;
    a_load  = 1'b0;
    g_load  = 1'b0;
    sub_sel = 1'b0;
    g_oe    = 1'b0;
    din_oe  = 1'b0;
    done    = 1'b0;
    reg_we  = '0;
    reg_oe  = '0;
    case (step)
      STEP_FETCH: ir_load = 1'b1;
      STEP_1: begin
        case (opc)
          OPC_MOVE: begin
            reg_oe[ry] = 1'b1;
            reg_we[rx] = 1'b1;
            done       = 1'b1;
          end
          OPC_LOADI: begin
            din_oe     = 1'b1;
            reg_we[rx] = 1'b1;
            done       = 1'b1;
          end
          OPC_ADD, OPC_SUB: begin
            reg_oe[rx] = 1'b1;
            a_load     = 1'b1;
          end
          default: done = 1'b1;
        endcase
      end
      STEP_2: begin
        reg_oe[ry] = 1'b1;
        g_load     = 1'b1;
        sub_sel    = (opc == OPC_SUB);
      end
      default: begin
        g_oe       = 1'b1;
        reg_we[rx] = 1'b1;
        done       = 1'b1;
      end
    endcase
  end

  // R1: no completion and no register write while fetching
  a_r1_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_FETCH) |-> (!done && reg_we == '0));
  // R9: completion is followed by the fetch step
  a_r9_done_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (step == STEP_FETCH));
  // R3: at most one destination register per cycle
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we));
  // R8: reserved opcodes finish without writing
  a_r8_reserved_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_1 && opc[OPC_W-1]) |-> (done && reg_we == '0 && !a_load));
  // R5: step 3 is only reached through step 2
  a_r5_step_order: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_3) |-> ($past(step) == STEP_2));
endmodule

// File: rtl/bus_cpu_regs.sv
module bus_cpu_regs #(
  parameter int NREG   = 8,
  parameter int DATA_W = 9
) (
  input  logic                        clk,
  input  logic [NREG-1:0]             we,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NREG-1:0][DATA_W-1:0] q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we[i]) q[i] <= wdata;
    end
  end
endmodule

// File: rtl/bus_cpu_busmux.sv
module bus_cpu_busmux #(
  parameter int NREG   = 8,
  parameter int DATA_W = 9
) (
  input  logic [NREG-1:0][DATA_W-1:0] reg_q,
  input  logic [NREG-1:0]             reg_oe,
  input  logic [DATA_W-1:0]           g_q,
  input  logic                        g_oe,
  input  logic [DATA_W-1:0]           din,
  input  logic                        din_oe,
  output logic [DATA_W-1:0]           bus
);
  always_comb begin
    bus = ({DATA_W{g_oe}} & g_q) | ({DATA_W{din_oe}} & din);
    for (int i = 0; i < NREG; i++) begin
      bus = bus | ({DATA_W{reg_oe[i]}} & reg_q[i]);
    end
  end
endmodule

// File: rtl/bus_cpu.sv
module bus_cpu
  import bus_cpu_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] din,
  output logic              done,
  output logic [DATA_W-1:0] bus_out
);
  localparam int SEL_W = $clog2(NREG);
  localparam int IR_W  = OPC_W + 2 * SEL_W;

  function automatic logic [DATA_W-1:0] addsub(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic sub);
    return sub ? (x - y) : (x + y);
  endfunction

  step_t                      step;
  logic                       ir_load, a_load, g_load, sub_sel, g_oe, din_oe;
  logic [NREG-1:0]            reg_we, reg_oe;
  logic [IR_W-1:0]            ir_q;
  logic [DATA_W-1:0]          a_q, g_q, bus;
  logic [NREG-1:0][DATA_W-1:0] reg_q;

  bus_cpu_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .ir(ir_q), .step(step),
    .ir_load(ir_load), .a_load(a_load), .g_load(g_load), .sub_sel(sub_sel),
    .g_oe(g_oe), .din_oe(din_oe), .done(done), .reg_we(reg_we), .reg_oe(reg_oe)
  );

  bus_cpu_regs #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .we(reg_we), .wdata(bus), .q(reg_q)
  );

  bus_cpu_busmux #(.NREG(NREG), .DATA_W(DATA_W)) u_mux (
    .reg_q(reg_q), .reg_oe(reg_oe), .g_q(g_q), .g_oe(g_oe),
    .din(din), .din_oe(din_oe), .bus(bus)
  );

  always_ff @(posedge clk) begin
    if (ir_load) ir_q <= din[IR_W-1:0];
    if (a_load)  a_q  <= bus;
    if (g_load)  g_q  <= addsub(a_q, bus, sub_sel);
  end

  assign bus_out = bus;

  // R2: the bus never has more than one driver
  a_r2_bus_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_oe, g_oe, din_oe}));
  // R4: load immediate routes the data input onto the bus
  a_r4_loadi_uses_din: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_1 && ir_q[IR_W-1 -: OPC_W] == OPC_LOADI) |-> (bus == din));
  // R5: the write-back step carries the result latch
  a_r5_writeback_from_g: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_3) |-> (bus == g_q && done));
  // R1: idle bus is zero
  a_r1_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_FETCH) |-> (bus == '0));
endmodule

// File: tb/bus_cpu_bench.sv
module bus_cpu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [8:0] din = '0;
  logic       done;
  logic [8:0] bus_out;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  bus_cpu u_bus_cpu (.clk(clk), .rst_n(rst_n), .run(run), .din(din),
                     .done(done), .bus_out(bus_out));

  localparam int NVEC = 12;
  // instruction word, immediate, expected bus value in the done step
  localparam logic [8:0] VEC_WORD [NVEC] = '{
    9'o100, 9'o110, 9'o020, 9'o221, 9'o130, 9'o330,
    9'o232, 9'o300, 9'o170, 9'o277, 9'o047, 9'o156};
  localparam logic [8:0] VEC_IMM [NVEC] = '{
    9'h005, 9'h1F0, 9'h000, 9'h000, 9'h003, 9'h000,
    9'h000, 9'h000, 9'h1FF, 9'h000, 9'h000, 9'h0AA};
  localparam logic [8:0] VEC_EXP [NVEC] = '{
    9'h005, 9'h1F0, 9'h005, 9'h1F5, 9'h003, 9'h1FE,
    9'h1F3, 9'h000, 9'h1FF, 9'h1FE, 9'h1FE, 9'h0AA};

  logic [8:0] model [8];

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one instruction; checks latency, intermediate bus values and result.
  task automatic exec(input logic [8:0] word, input logic [8:0] imm,
                      input logic [8:0] exp, input string req);
    int lat;
    int steps;
    logic [2:0] opc, rx, ry;
    opc = word[8:6]; rx = word[5:3]; ry = word[2:0];
    steps = (opc == 3'b010 || opc == 3'b011) ? 3 : 1;
    @(negedge clk); din = word; run = 1'b1;
    @(negedge clk); run = 1'b0; din = imm;
    #1;
    lat = 1;
    while (!done && lat < 6) begin
      if (steps == 3 && lat == 1) check("R5 step1 bus=RX", bus_out, model[rx]);
      if (steps == 3 && lat == 2) check("R5 step2 bus=RY", bus_out, model[ry]);
      @(negedge clk); #1;
      lat++;
    end
    check({req, " latency"}, 9'(lat), 9'(steps));
    check({req, " result"}, bus_out, exp);
    if (opc[2] == 1'b0) model[rx] = exp;
    @(negedge clk); #1;
    check("R9 idle after done", {bus_out[7:0], done}, 9'h000);
  endtask

  task automatic read_reg(input logic [2:0] k, input logic [8:0] exp, input string req);
    exec({3'b000, k, k}, 9'h000, exp, req);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle with run low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R1 idle done", {8'h00, done}, 9'h000);
      check("R1 idle bus", bus_out, 9'h000);
    end
    // R2 R3 R4 R5 R6 R7: instruction table
    for (int i = 0; i < NVEC; i++) begin
      exec(VEC_WORD[i], VEC_IMM[i], VEC_EXP[i], "R2/table");
    end
    read_reg(3'd2, 9'h1F5, "R5 add wrote R2");
    read_reg(3'd3, 9'h1F3, "R6 sub/add wrote R3");
    read_reg(3'd7, 9'h1FE, "R7 wrap in R7");
    read_reg(3'd5, 9'h0AA, "R4 Y ignored");
    // R8: reserved opcodes
    exec(9'o160, 9'h0C3, 9'h0C3, "R4 load R6");
    exec(9'o566, 9'h1FF, 9'h000, "R8 op101");
    exec(9'o760, 9'h1FF, 9'h000, "R8 op111");
    read_reg(3'd6, 9'h0C3, "R8 R6 unchanged");
    // R6 R7: subtract borrow
    exec(9'o110, 9'h000, 9'h000, "R4 load R1");
    exec(9'o316, 9'h1FF, 9'h13D, "R6 R7 0-0C3 wrap");
    // R10: reset inside an add
    exec(9'o110, 9'h011, 9'h011, "R4 load R1");
    @(negedge clk); din = 9'o211; run = 1'b1;
    @(negedge clk); run = 1'b0; #1;
    check("R10 step1 bus", bus_out, 9'h011);
    @(posedge clk); #3;
    rst_n = 1'b0; #1;
    check("R10 async done", {8'h00, done}, 9'h000);
    check("R10 async bus", bus_out, 9'h000);
    @(negedge clk); rst_n = 1'b1;
    read_reg(3'd1, 9'h011, "R10 R1 unchanged");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule